// File: doc/BRIEF.md
# Port Overload Fault Timer

This block supervises the load current of one powered port. Two comparator results come in each clock cycle. The first says the current is above the soft cut threshold. The second says the current is above the hard limit threshold, where the analog loop is actively limiting. The block turns these into two fault timers. When either timer reaches its programmed expiry value, the block raises a sticky fault flag and a request to switch the port off. The power sequencer acts on that request.

The cut timer works as a leaky bucket. Each cycle spent above the cut threshold adds one count. Below the threshold, the count drains at one sixteenth of that rate, down to a floor of zero. Short overloads with a low duty cycle, under about 6%, therefore never reach expiry. Longer or more frequent overloads build up and trip the port. The limit timer has no such memory: it measures one unbroken stretch of active limiting. The threshold levels and the limiting action itself are outside this block.

Top module: `overload_guard`

## Requirements
- R1: While `rstN` is low or `portOn` is low at a clock edge, both fault flags and `offReq` are 0 after that edge, and both timers return to zero. After the port comes back, a full expiry count is needed again before any fault.
- R2: With `portOn` high and the cut timer at zero, holding `overCut` high trips the cut timer. `cutFault` goes to 1 after exactly `cutExpiry` consecutive edges with `overCut` high, and not after `cutExpiry`-1.
- R3: Each edge with `overCut` low drains the cut timer by one count every 16th such edge. The count of low edges restarts whenever `overCut` is high. So 8 up-counts followed by 64 low edges leave 4 counts, and 8 up-counts followed by 63 low edges leave 5.
- R4: The cut timer never drains below zero. Any number of low edges from zero still need the full `cutExpiry` edges of overload to trip.
- R5: `limFault` goes to 1 after `limExpiry` consecutive edges with `overLim` high. One edge with `overLim` low restarts the limit timer from zero.
- R6: `offReq` is 1 exactly when at least one fault flag is set. The flags hold at 1, whatever the comparators do, until the port goes off or reset is applied.
- R7: An overload on 1 of every 20 cycles never trips the cut timer. An overload on 2 of every 20 cycles trips it within a bounded number of periods.
- R8: While `portOn` is low, `overCut` and `overLim` have no effect. Once the port turns on, a full expiry count is still required.
- R9: The two timers are independent. A cut trip leaves `limFault` at 0, and a limit trip leaves `cutFault` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| portOn | input | 1 | Port is powered; low clears timers and faults |
| overCut | input | 1 | Current above cut threshold |
| overLim | input | 1 | Current above limit threshold, limiting active |
| cutExpiry | input | TW | Cut timer expiry count |
| limExpiry | input | TW | Limit timer expiry count |
| offReq | output | 1 | Request to switch the port off |
| cutFault | output | 1 | Cut timer expired |
| limFault | output | 1 | Limit timer expired |

## Verification
The timer counts are internal, so a wrong count shows only in the cycle where a fault rises. A counter that is off by one, drains at the wrong rate, or wraps below zero moves the trip edge earlier or later by one or more cycles. It can also make a trip appear that should never happen. Each scenario therefore sets up a known residual count and checks the fault flags one edge before and at the predicted trip edge. A stuck or non-sticky flag shows in the same cycle through `offReq`.

// File: rtl/ovg_pkg.sv
package ovg_pkg;
  // strobes from control to datapath, one per cycle
  typedef struct packed {
    logic clr;     // drop both timers to zero
    logic cutUp;   // cut timer +1
    logic cutDn;   // cut timer -1 (floored)
    logic limUp;   // limit timer +1
    logic limRst;  // limit timer back to zero
  } ovgStb_t;
endpackage

// File: rtl/ovg_ctrl.sv
module ovg_ctrl
  import ovg_pkg::*;
#(
  parameter int DOWN_DIV = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    portOn,
  input  logic    overCut,
  input  logic    overLim,
  input  logic    cutReach,
  input  logic    limReach,
  output ovgStb_t stb,
  output logic    cutFault,
  output logic    limFault
);
  localparam int PW = (DOWN_DIV > 1) ? $clog2(DOWN_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DOWN_DIV - 1);

  logic [PW-1:0] preCnt;
  logic          clr;
  logic          tick;

  assign clr  = !rstN || !portOn;
  assign tick = !overCut && (preCnt == PRE_LAST);

  // below-threshold cycle divider; restarts on any overload cycle
  always_ff @(posedge clk) begin
    if (clr || overCut)  preCnt <= '0;
    else if (tick)       preCnt <= '0;
    else                 preCnt <= preCnt + PW'(1);
  end

  always_comb begin
    stb.clr    = clr;
    stb.cutUp  = overCut;
    stb.cutDn  = tick;
    stb.limUp  = overLim;
    stb.limRst = !overLim;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cutFault <= 1'b0;
      limFault <= 1'b0;
    end else begin
      if (overCut && cutReach) cutFault <= 1'b1;
      if (overLim && limReach) limFault <= 1'b1;
    end
  end
endmodule

// File: rtl/ovg_dp.sv
module ovg_dp
  import ovg_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  ovgStb_t       stb,
  input  logic [TW-1:0] cutExpiry,
  input  logic [TW-1:0] limExpiry,
  output logic          cutReach,
  output logic          limReach
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cutCnt;
  logic [TW-1:0] limCnt;

  // the count after this edge reaches the expiry value
  assign cutReach = ({1'b0, cutCnt} + (TW+1)'(1)) >= {1'b0, cutExpiry};
  assign limReach = ({1'b0, limCnt} + (TW+1)'(1)) >= {1'b0, limExpiry};

  always_ff @(posedge clk) begin
    if (stb.clr)                           cutCnt <= '0;
    else if (stb.cutUp && cutCnt != CNT_MAX) cutCnt <= cutCnt + TW'(1);
    else if (stb.cutDn && cutCnt != '0)      cutCnt <= cutCnt - TW'(1);
  end

  always_ff @(posedge clk) begin
    if (stb.clr || stb.limRst)             limCnt <= '0;
    else if (stb.limUp && limCnt != CNT_MAX) limCnt <= limCnt + TW'(1);
  end
endmodule

// File: rtl/overload_guard.sv
module overload_guard
  import ovg_pkg::*;
#(
  parameter int TW       = 12,
  parameter int DOWN_DIV = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          portOn,
  input  logic          overCut,
  input  logic          overLim,
  input  logic [TW-1:0] cutExpiry,
  input  logic [TW-1:0] limExpiry,
  output logic          offReq,
  output logic          cutFault,
  output logic          limFault
);
  ovgStb_t stb;
  logic    cutReach;
  logic    limReach;

  ovg_ctrl #(.DOWN_DIV(DOWN_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .portOn(portOn),
    .overCut(overCut), .overLim(overLim),
    .cutReach(cutReach), .limReach(limReach),
    .stb(stb), .cutFault(cutFault), .limFault(limFault)
  );

  ovg_dp #(.TW(TW)) u_dp (
    .clk(clk), .stb(stb),
    .cutExpiry(cutExpiry), .limExpiry(limExpiry),
    .cutReach(cutReach), .limReach(limReach)
  );

  assign offReq = cutFault | limFault;
endmodule

// File: rtl/overload_guard_chk.sv
module overload_guard_chk (
  input logic clk,
  input logic rstN,
  input logic portOn,
  input logic overCut,
  input logic overLim,
  input logic offReq,
  input logic cutFault,
  input logic limFault
);
  // R1
  port_off_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portOn |=> (!cutFault && !limFault && !offReq));

  // R6
  cut_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portOn && cutFault) |=> cutFault);

  // R6
  lim_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portOn && limFault) |=> limFault);

  // R2
  cut_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cutFault) |-> $past(overCut));

  // R5
  lim_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(limFault) |-> $past(overLim));

  // R6
  off_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offReq) |-> $past(overCut || overLim));
endmodule

bind overload_guard overload_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .portOn(portOn),
  .overCut(overCut), .overLim(overLim),
  .offReq(offReq), .cutFault(cutFault), .limFault(limFault)
);

// File: tb/sim_overload_guard.sv
module sim_overload_guard;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          portOn = 1'b0;
  logic          overCut = 1'b0;
  logic          overLim = 1'b0;
  logic [TW-1:0] cutExpiry = TW'(10);
  logic [TW-1:0] limExpiry = TW'(1000);
  logic          offReq, cutFault, limFault;

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;

  overload_guard #(.TW(TW), .DOWN_DIV(16)) u0 (
    .clk(clk), .rstN(rstN), .portOn(portOn),
    .overCut(overCut), .overLim(overLim),
    .cutExpiry(cutExpiry), .limExpiry(limExpiry),
    .offReq(offReq), .cutFault(cutFault), .limFault(limFault)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nBad = nBad + 1;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    nChk = nChk + 1;
    if (act !== exp) begin
      nBad = nBad + 1;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // inputs change just after a falling edge; outputs are read there too
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fresh(input int cutE, input int limE);
    portOn = 1'b0; overCut = 1'b0; overLim = 1'b0;
    cutExpiry = TW'(cutE); limExpiry = TW'(limE);
    run(1);
    portOn = 1'b1;
  endtask

  task automatic t_reset();
    portOn = 1'b1; overCut = 1'b1; overLim = 1'b1;
    run(20);
    check("R1 reset cutFault", cutFault, 1'b0);
    check("R1 reset limFault", limFault, 1'b0);
    check("R1 reset offReq", offReq, 1'b0);
    rstN = 1'b1;
    fresh(10, 1000);
  endtask

  task automatic t_cutExact();
    fresh(10, 1000);
    overCut = 1'b1;
    run(9);
    check("R2 before expiry", cutFault, 1'b0);
    run(1);
    check("R2 at expiry", cutFault, 1'b1);
    check("R6 offReq on cut", offReq, 1'b1);
    check("R9 lim untouched", limFault, 1'b0);
    overCut = 1'b0;
    run(40);
    check("R6 cut sticky", cutFault, 1'b1);
    check("R6 offReq sticky", offReq, 1'b1);
  endtask

  task automatic t_drain(input int lowEdges, input int left);
    fresh(10, 1000);
    overCut = 1'b1; run(8);
    overCut = 1'b0; run(lowEdges);
    overCut = 1'b1; run(10 - left - 1);
    check("R3 drain early", cutFault, 1'b0);
    run(1);
    check("R3 drain trip", cutFault, 1'b1);
  endtask

  task automatic t_floor();
    fresh(10, 1000);
    run(100);
    overCut = 1'b1; run(9);
    check("R4 floor early", cutFault, 1'b0);
    run(1);
    check("R4 floor trip", cutFault, 1'b1);
  endtask

  task automatic t_limit();
    fresh(1000, 5);
    overLim = 1'b1; run(4);
    overLim = 1'b0; run(1);
    overLim = 1'b1; run(4);
    check("R5 restart", limFault, 1'b0);
    run(1);
    check("R5 trip", limFault, 1'b1);
    check("R6 offReq on lim", offReq, 1'b1);
    check("R9 cut untouched", cutFault, 1'b0);
  endtask

  task automatic t_duty();
    fresh(8, 1000);
    for (int p = 0; p < 100; p++) begin
      overCut = 1'b1; run(1);
      overCut = 1'b0; run(19);
    end
    check("R7 5pct tolerated", cutFault, 1'b0);
    fresh(8, 1000);
    for (int p = 0; p < 30; p++) begin
      overCut = 1'b1; run(2);
      overCut = 1'b0; run(18);
    end
    check("R7 10pct trips", cutFault, 1'b1);
  endtask

  task automatic t_portOff();
    fresh(10, 3);
    overCut = 1'b1; overLim = 1'b1; run(12);
    check("R1 both set", offReq, 1'b1);
    portOn = 1'b0; run(1);
    check("R1 off cutFault", cutFault, 1'b0);
    check("R1 off limFault", limFault, 1'b0);
    check("R1 off offReq", offReq, 1'b0);
    portOn = 1'b1; overLim = 1'b0; run(9);
    check("R1 full count again", cutFault, 1'b0);
    run(1);
    check("R1 retrip", cutFault, 1'b1);
    overCut = 1'b0;
  endtask

  task automatic t_ignoreOff();
    fresh(10, 4);
    portOn = 1'b0; overCut = 1'b1; overLim = 1'b1;
    run(50);
    check("R8 off cut ignored", cutFault, 1'b0);
    check("R8 off lim ignored", limFault, 1'b0);
    portOn = 1'b1; overLim = 1'b0;
    run(9);
    check("R8 full count after on", cutFault, 1'b0);
    run(1);
    check("R8 trip after on", cutFault, 1'b1);
    overCut = 1'b0;
  endtask

  initial begin
    run(1);
    t_reset();
    t_cutExact();
    t_drain(64, 4);
    t_drain(63, 5);
    t_floor();
    t_limit();
    t_duty();
    t_portOff();
    t_ignoreOff();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule